// File: doc/BRIEF.md
# Parallel NOR flash command sequencer

This block sits behind a simple synchronous memory bus and behaves like a small parallel NOR flash that follows the common unlock-and-command write protocol. A write is never stored directly. The block watches the stream of bus writes for the two-cycle unlock preamble and then for a command byte. Depending on that byte, it programs one word, erases one sector or the whole array, reports identification words, or exposes a query table. The array it guards is held inside the block and is read through the same bus. The word width is 8, 16 or 32 bits.

Programming can only clear bits: the addressed word becomes the AND of its old value and the written data. Erase sets words back to all ones in a single clock. The block then stays in an erasing mode until a separate status engine reports completion on `erase_done_i`. That engine is told about each erase through a one-cycle start pulse that carries a chip-or-sector flag, and it follows the `mode_o` output. An unlock-bypass mode lets software issue commands without repeating the preamble and without an address check.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset every array word reads as all ones, and `mode_o` is 0. The `mode_o` codes are 0 for array read, 1 for a sequence in progress (unlock, command wait, program-data wait, erase setup), 2 for ID read, 3 for query, and 4 for erasing. A read returns its data on `rd_data_o` one cycle after `rd_en_i`.
- R2: A command is accepted only after two writes: low byte 0xAA at word offset UNLOCK0, then 0x55 at UNLOCK1. It must then be written at UNLOCK0. A word offset is the word index within its sector, where the word index is the byte address shifted right by log2(WORD_W/8). Any mismatch returns the block to mode 0 without touching the array.
- R3: Command 0xA0 makes the next write program its word as old AND data. The block then returns to mode 0, or to command wait when bypass is active.
- R4: A write with low byte 0xF0 returns the block to mode 0 and clears bypass, in every state except program-data wait (where it is programmed as data) and erasing.
- R5: Command 0x80, a second unlock pair, then 0x10 at UNLOCK0 sets the whole array to all ones. It raises `erase_start_o` for exactly one cycle with `erase_chip_o`=1 and enters mode 4. A final 0x10 at any other offset aborts to mode 0 and no erase starts.
- R6: The same sequence ending in 0x30 at any address sets to all ones only the sector holding that address, with `erase_chip_o`=0.
- R7: In mode 4 every write is ignored, including 0xF0. A high `erase_done_i` returns the block to mode 0, or to command wait (mode 1) in bypass.
- R8: Command 0x20 enters bypass. Further commands are then taken at any address without an unlock pair, and bypass survives program and erase.
- R9: Command 0x90 enters mode 2. Reads at word offsets 0, 1, 14 and 15 return ID0, ID1, ID2 and ID3, unless that ID equals 0x00FF. Offset 2 returns 0. Every other read returns array data.
- R10: In bypass with mode 2 active, a write of 0x00 leaves bypass and returns to mode 0.
- R11: Writing 0x98 at word offset 0x55 from mode 0 or mode 2 enters mode 3. Reads at offsets 0x10, 0x11 and 0x12 return 0x51, 0x52 and 0x59. Offset 0x27 returns log2 of the array size in bytes, and offset 0x2D returns the sector count minus one. Any write in mode 3 returns the block to mode 0.
- R12: While `ro_i` is high, program and erase leave the array unchanged, and sequencing, modes and erase pulses behave as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Byte address of the access |
| wr_en_i | input | 1 | Write strobe, one bus write per cycle |
| wr_data_i | input | WORD_W | Write data; the low byte is the command |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | WORD_W | Read data, valid the cycle after the strobe |
| ro_i | input | 1 | Blocks all array changes |
| erase_done_i | input | 1 | Erase completion from the status engine |
| erase_start_o | output | 1 | One-cycle pulse when an erase begins |
| erase_chip_o | output | 1 | Kind of the latest erase: 1 chip, 0 sector |
| mode_o | output | 3 | Current mode code |

## Verification
A sequencer stuck in the wrong state shows up on `mode_o` right at the falling edge after the write that went wrong. A word that was misprogrammed or erased in the wrong sector shows up on the first later read of that word, one cycle after the strobe. Bypass state has no output of its own. It is exposed by issuing an unlocked command and checking whether the mode moves. Random programs and sector erases are compared word by word against a bench shadow array, so a bad AND, an off-by-one sector boundary or a lost ro gate appears within the few reads that follow.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    typedef enum logic [3:0] {
        S_READ, S_UNLK1, S_CMD, S_PROG, S_ESET, S_EUNLK1, S_ECMD,
        S_ERASE, S_ASEL, S_CFI
    } seq_state_t;

    typedef enum logic [2:0] {
        MODE_ARRAY = 3'd0,
        MODE_SEQ   = 3'd1,
        MODE_ID    = 3'd2,
        MODE_CFI   = 3'd3,
        MODE_ERASE = 3'd4
    } mode_t;

    typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_CHIP, OP_SECT} arr_op_t;

    localparam logic [7:0] C_UNLK_A = 8'hAA;
    localparam logic [7:0] C_UNLK_B = 8'h55;
    localparam logic [7:0] C_BYPASS = 8'h20;
    localparam logic [7:0] C_ESETUP = 8'h80;
    localparam logic [7:0] C_IDREAD = 8'h90;
    localparam logic [7:0] C_PROG   = 8'hA0;
    localparam logic [7:0] C_ABORT  = 8'hF0;
    localparam logic [7:0] C_QUERY  = 8'h98;
    localparam logic [7:0] C_CHIP   = 8'h10;
    localparam logic [7:0] C_SECT   = 8'h30;
    localparam logic [7:0] C_BPEXIT = 8'h00;
    localparam int         QUERY_OFF = 'h55;

    function automatic mode_t mode_of(input seq_state_t s);
        case (s)
            S_READ:  return MODE_ARRAY;
            S_ASEL:  return MODE_ID;
            S_CFI:   return MODE_CFI;
            S_ERASE: return MODE_ERASE;
            default: return MODE_SEQ;
        endcase
    endfunction

    // Query table byte at a word offset, computed from the geometry.
    function automatic logic [7:0] cfi_byte(input int off, input int chip_log2,
                                            input int nsect, input int sect_bytes);
        case (off)
            'h10:    return 8'h51;
            'h11:    return 8'h52;
            'h12:    return 8'h59;
            'h13:    return 8'h02;
            'h27:    return 8'(chip_log2);
            'h2C:    return 8'h01;
            'h2D:    return 8'(nsect - 1);
            'h2E:    return 8'((nsect - 1) >> 8);
            'h2F:    return 8'(sect_bytes >> 8);
            'h30:    return 8'(sect_bytes >> 16);
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/nfc_addr_dec.sv
module nfc_addr_dec #(
    parameter int ADDR_W = 10,
    parameter int BSH    = 1,
    parameter int SOFF_W = 7,
    parameter int SECT_W = 2
) (
    input  logic [ADDR_W-1:0]        addr_i,
    output logic [SOFF_W-1:0]        off_o,
    output logic [SECT_W-1:0]        sect_o,
    output logic [SOFF_W+SECT_W-1:0] widx_o
);
    localparam int WIDX_W = SOFF_W + SECT_W;

    assign widx_o = addr_i[BSH +: WIDX_W];
    assign off_o  = widx_o[SOFF_W-1:0];
    assign sect_o = widx_o[WIDX_W-1:SOFF_W];

    generate
        if (BSH > 0) begin : g_lane
            logic unused_lane;
            assign unused_lane = ^addr_i[BSH-1:0];
        end
    endgenerate
endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
    import nfc_pkg::*;
#(
    parameter int SOFF_W  = 7,
    parameter int UNLOCK0 = 'h55,
    parameter int UNLOCK1 = 'h2A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [7:0]        cmd_i,
    input  logic [SOFF_W-1:0] off_i,
    input  logic              erase_done_i,
    output arr_op_t           op_o,
    output mode_t             mode_o,
    output logic              erase_start_o,
    output logic              erase_chip_o
);
    localparam logic [SOFF_W-1:0] U0 = SOFF_W'(UNLOCK0);
    localparam logic [SOFF_W-1:0] U1 = SOFF_W'(UNLOCK1);
    localparam logic [SOFF_W-1:0] QO = SOFF_W'(QUERY_OFF);

    seq_state_t st, nxt;
    logic       byp, nbyp;
    logic       start, chip;

    always_comb begin
        nxt   = st;
        nbyp  = byp;
        op_o  = OP_NONE;
        start = 1'b0;
        chip  = erase_chip_o;
        if (st == S_ERASE) begin
            if (erase_done_i) nxt = byp ? S_CMD : S_READ;
        end else if (wr_en_i) begin
            if (cmd_i == C_ABORT && st != S_PROG) begin
                nxt  = S_READ;
                nbyp = 1'b0;
            end else begin
                // default outcome of every mismatch: back to read, bypass off
                nxt  = S_READ;
                nbyp = 1'b0;
                case (st)
                    S_READ: begin
                        if (off_i == QO && cmd_i == C_QUERY) nxt = S_CFI;
                        else if (off_i == U0 && cmd_i == C_UNLK_A) nxt = S_UNLK1;
                    end
                    S_UNLK1: begin
                        if (off_i == U1 && cmd_i == C_UNLK_B) nxt = S_CMD;
                    end
                    S_CMD: begin
                        if (byp || off_i == U0) begin
                            case (cmd_i)
                                C_BYPASS: begin nxt = S_CMD;  nbyp = 1'b1; end
                                C_ESETUP: begin nxt = S_ESET; nbyp = byp;  end
                                C_IDREAD: begin nxt = S_ASEL; nbyp = byp;  end
                                C_PROG:   begin nxt = S_PROG; nbyp = byp;  end
                                default:  ;
                            endcase
                        end
                    end
                    S_PROG: begin
                        op_o = OP_PROG;
                        nbyp = byp;
                        nxt  = byp ? S_CMD : S_READ;
                    end
                    S_ESET: begin
                        if (off_i == U0 && cmd_i == C_UNLK_A) begin
                            nxt = S_EUNLK1; nbyp = byp;
                        end
                    end
                    S_EUNLK1: begin
                        if (off_i == U1 && cmd_i == C_UNLK_B) begin
                            nxt = S_ECMD; nbyp = byp;
                        end
                    end
                    S_ECMD: begin
                        if (cmd_i == C_CHIP && off_i == U0) begin
                            op_o = OP_CHIP; nxt = S_ERASE; nbyp = byp;
                            start = 1'b1; chip = 1'b1;
                        end else if (cmd_i == C_SECT) begin
                            op_o = OP_SECT; nxt = S_ERASE; nbyp = byp;
                            start = 1'b1; chip = 1'b0;
                        end
                    end
                    S_ASEL: begin
                        if (!(byp && cmd_i == C_BPEXIT) && off_i == QO && cmd_i == C_QUERY)
                            nxt = S_CFI;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= S_READ;
            byp           <= 1'b0;
            erase_start_o <= 1'b0;
            erase_chip_o  <= 1'b0;
        end else begin
            st            <= nxt;
            byp           <= nbyp;
            erase_start_o <= start;
            erase_chip_o  <= chip;
        end
    end

    assign mode_o = mode_of(st);

    assert_abort_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && cmd_i == C_ABORT && st != S_PROG && st != S_ERASE)
        |=> (st == S_READ && !byp));

    assert_erase_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (st == S_ERASE && !erase_done_i) |=> (st == S_ERASE));

    assert_query_exit_R11: assert property (@(posedge clk) disable iff (rst)
        (st == S_CFI && wr_en_i) |=> (st == S_READ));

    assert_start_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        erase_start_o |-> (st == S_ERASE) ##1 !erase_start_o);
endmodule

// File: rtl/nfc_array.sv
module nfc_array
    import nfc_pkg::*;
#(
    parameter int          WORD_W   = 16,
    parameter int          SOFF_W   = 7,
    parameter int          SECT_W   = 2,
    parameter int          CHIP_L2  = 10,
    parameter logic [31:0] ID0      = 32'h0001,
    parameter logic [31:0] ID1      = 32'h227E,
    parameter logic [31:0] ID2      = 32'h00FF,
    parameter logic [31:0] ID3      = 32'h2201
) (
    input  logic                     clk,
    input  logic                     rst,
    input  arr_op_t                  op_i,
    input  logic [SOFF_W+SECT_W-1:0] widx_i,
    input  logic [SOFF_W-1:0]        off_i,
    input  logic [SECT_W-1:0]        sect_i,
    input  logic [WORD_W-1:0]        data_i,
    input  logic                     ro_i,
    input  logic                     rd_en_i,
    input  mode_t                    mode_i,
    output logic [WORD_W-1:0]        rd_data_o
);
    localparam int DEPTH      = 1 << (SOFF_W + SECT_W);
    localparam int NSECT      = 1 << SECT_W;
    localparam int SECT_BYTES = (1 << SOFF_W) * (WORD_W / 8);
    localparam logic [WORD_W-1:0] ID_BLANK = WORD_W'(8'hFF);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] id_val;
    logic              id_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (!ro_i) begin
            case (op_i)
                OP_PROG: mem[widx_i] <= mem[widx_i] & data_i;
                OP_CHIP: for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
                OP_SECT: for (int i = 0; i < DEPTH; i++)
                             if (SECT_W'(i >> SOFF_W) == sect_i) mem[i] <= '1;
                default: ;
            endcase
        end
    end

    always_comb begin
        id_hit = 1'b1;
        case (int'(off_i))
            0:       id_val = WORD_W'(ID0);
            1:       id_val = WORD_W'(ID1);
            2:       id_val = '0;
            14:      id_val = WORD_W'(ID2);
            15:      id_val = WORD_W'(ID3);
            default: begin id_val = '0; id_hit = 1'b0; end
        endcase
        if (int'(off_i) != 2 && id_val == ID_BLANK) id_hit = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_o <= '0;
        end else if (rd_en_i) begin
            case (mode_i)
                MODE_ID:  rd_data_o <= id_hit ? id_val : mem[widx_i];
                MODE_CFI: rd_data_o <= WORD_W'(cfi_byte(int'(off_i), CHIP_L2,
                                                        NSECT, SECT_BYTES));
                default:  rd_data_o <= mem[widx_i];
            endcase
        end
    end

    assert_chip_fill_R5: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CHIP && !ro_i) |=> (mem[0] == '1 && mem[DEPTH-1] == '1));

    assert_ro_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (ro_i && op_i != OP_NONE) |=> ($stable(mem[0]) && $stable(mem[DEPTH-1])));
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nfc_pkg::*;
#(
    parameter int          WORD_W     = 16,
    parameter int          SECT_WORDS = 128,
    parameter int          NUM_SECT   = 4,
    parameter int          UNLOCK0    = 'h55,
    parameter int          UNLOCK1    = 'h2A,
    parameter logic [31:0] ID0        = 32'h0001,
    parameter logic [31:0] ID1        = 32'h227E,
    parameter logic [31:0] ID2        = 32'h00FF,
    parameter logic [31:0] ID3        = 32'h2201,
    localparam int         BSH        = $clog2(WORD_W / 8),
    localparam int         SOFF_W     = $clog2(SECT_WORDS),
    localparam int         SECT_W     = $clog2(NUM_SECT),
    localparam int         ADDR_W     = SOFF_W + SECT_W + BSH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [WORD_W-1:0] rd_data_o,
    input  logic              ro_i,
    input  logic              erase_done_i,
    output logic              erase_start_o,
    output logic              erase_chip_o,
    output logic [2:0]        mode_o
);
    logic [SOFF_W-1:0]        off;
    logic [SECT_W-1:0]        sect;
    logic [SOFF_W+SECT_W-1:0] widx;
    arr_op_t                  op;
    mode_t                    mode;

    nfc_addr_dec #(.ADDR_W(ADDR_W), .BSH(BSH), .SOFF_W(SOFF_W), .SECT_W(SECT_W)) u_dec (
        .addr_i (addr_i),
        .off_o  (off),
        .sect_o (sect),
        .widx_o (widx)
    );

    nfc_seq #(.SOFF_W(SOFF_W), .UNLOCK0(UNLOCK0), .UNLOCK1(UNLOCK1)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .wr_en_i       (wr_en_i),
        .cmd_i         (wr_data_i[7:0]),
        .off_i         (off),
        .erase_done_i  (erase_done_i),
        .op_o          (op),
        .mode_o        (mode),
        .erase_start_o (erase_start_o),
        .erase_chip_o  (erase_chip_o)
    );

    nfc_array #(.WORD_W(WORD_W), .SOFF_W(SOFF_W), .SECT_W(SECT_W), .CHIP_L2(ADDR_W),
                .ID0(ID0), .ID1(ID1), .ID2(ID2), .ID3(ID3)) u_arr (
        .clk       (clk),
        .rst       (rst),
        .op_i      (op),
        .widx_i    (widx),
        .off_i     (off),
        .sect_i    (sect),
        .data_i    (wr_data_i),
        .ro_i      (ro_i),
        .rd_en_i   (rd_en_i),
        .mode_i    (mode),
        .rd_data_o (rd_data_o)
    );

    assign mode_o = mode;
endmodule

// File: tb/nor_cmd_seq_bench.sv
module nor_cmd_seq_bench;
    localparam int W = 16, SW = 128, NS = 4, DEPTH = SW * NS, AW = 10;
    localparam int U0 = 'h55, U1 = 'h2A;

    logic          clk = 1'b0, rst = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic          wr_en_i = 1'b0, rd_en_i = 1'b0, ro_i = 1'b0, erase_done_i = 1'b0;
    logic [W-1:0]  wr_data_i = '0;
    logic [W-1:0]  rd_data_o;
    logic          erase_start_o, erase_chip_o;
    logic [2:0]    mode_o;

    int nchk = 0, nerr = 0;
    logic [W-1:0] model [DEPTH];

    always #2.5 clk = ~clk;

    nor_cmd_seq #(.WORD_W(W), .SECT_WORDS(SW), .NUM_SECT(NS), .UNLOCK0(U0), .UNLOCK1(U1),
                  .ID0(32'h0001), .ID1(32'h227E), .ID2(32'h00FF), .ID3(32'h2201)) u_nor_cmd_seq (
        .clk(clk), .rst(rst), .addr_i(addr_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .ro_i(ro_i), .erase_done_i(erase_done_i),
        .erase_start_o(erase_start_o), .erase_chip_o(erase_chip_o), .mode_o(mode_o));

    function automatic int ix(input int s, input int o);
        return s * SW + o;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [W-1:0] d);
        addr_i = AW'(idx << 1); wr_data_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [W-1:0] v);
        addr_i = AW'(idx << 1); rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0; v = rd_data_o;
    endtask

    task automatic rd_chk(input string tag, input int idx, input logic [W-1:0] exp);
        logic [W-1:0] v;
        rd(idx, v);
        check(tag, v, exp);
    endtask

    task automatic unlock(input int s);
        wr(ix(s, U0), 16'h00AA);
        wr(ix(s, U1), 16'h0055);
    endtask

    task automatic prog(input int idx, input logic [W-1:0] d);
        unlock(idx / SW);
        wr(ix(0, U0), 16'h00A0);
        wr(idx, d);
        if (!ro_i) model[idx] &= d;
    endtask

    task automatic finish_erase(input logic [2:0] exp_mode, input string tag);
        erase_done_i = 1'b1;
        @(negedge clk);
        erase_done_i = 1'b0;
        check(tag, mode_o, exp_mode);
    endtask

    task automatic sect_erase(input int s, input int o);
        unlock(0); wr(ix(0, U0), 16'h0080); unlock(1);
        wr(ix(s, o), 16'h0030);
        check("R6 start", erase_start_o, 1'b1);
        check("R6 kind", erase_chip_o, 1'b0);
        if (!ro_i) for (int i = 0; i < SW; i++) model[ix(s, i)] = '1;
        finish_erase(3'd0, "R7 done");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL all watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [W-1:0] v;
        int unsigned seed;
        seed = $urandom(32'd4242);
        for (int i = 0; i < DEPTH; i++) model[i] = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 mode", mode_o, 3'd0);
        rd_chk("R1 erased", 0, 16'hFFFF);
        rd_chk("R1 erased", DEPTH - 1, 16'hFFFF);

        // R3 program in sector 3 with unlock at sector-relative offsets (R2)
        prog(ix(3, 9), 16'hA5C3);
        check("R3 mode", mode_o, 3'd0);
        rd_chk("R3 prog", ix(3, 9), 16'hA5C3);
        prog(ix(3, 9), 16'h0FF0);
        rd_chk("R3 and", ix(3, 9), 16'h05C0);

        // R2 bad second unlock
        wr(ix(0, U0), 16'h00AA); wr(ix(0, 'h2B), 16'h0055);
        check("R2 bad unlock", mode_o, 3'd0);
        wr(ix(0, U0), 16'h00A0); wr(ix(1, 3), 16'h0000);
        rd_chk("R2 no prog", ix(1, 3), 16'hFFFF);
        // R2 command at the wrong offset
        unlock(0); wr(ix(0, 'h10), 16'h00A0);
        check("R2 cmd addr", mode_o, 3'd0);
        wr(ix(1, 4), 16'h0000);
        rd_chk("R2 no prog2", ix(1, 4), 16'hFFFF);

        // R4 abort and the data-wait exception
        unlock(0);
        check("R4 pending", mode_o, 3'd1);
        wr(ix(0, 7), 16'h00F0);
        check("R4 abort", mode_o, 3'd0);
        prog(ix(1, 6), 16'h00F0);
        rd_chk("R4 data F0", ix(1, 6), 16'h00F0);

        // R9 ID reads
        prog(ix(0, 14), 16'h1234);
        unlock(0); wr(ix(0, U0), 16'h0090);
        check("R9 mode", mode_o, 3'd2);
        rd_chk("R9 id0", ix(0, 0), 16'h0001);
        rd_chk("R9 id1", ix(2, 1), 16'h227E);
        rd_chk("R9 prot", ix(0, 2), 16'h0000);
        rd_chk("R9 id2 blank", ix(0, 14), 16'h1234);
        rd_chk("R9 id3", ix(0, 15), 16'h2201);
        rd_chk("R9 other", ix(3, 9), 16'h05C0);
        // R11 query from ID mode
        wr(ix(0, 'h55), 16'h0098);
        check("R11 from id", mode_o, 3'd3);
        rd_chk("R11 Q", ix(1, 'h10), 16'h0051);
        rd_chk("R11 R", ix(0, 'h11), 16'h0052);
        rd_chk("R11 Y", ix(0, 'h12), 16'h0059);
        rd_chk("R11 size", ix(0, 'h27), 16'h000A);
        rd_chk("R11 nsect", ix(0, 'h2D), 16'h0003);
        wr(ix(0, 3), 16'h00AA);
        check("R11 exit", mode_o, 3'd0);
        wr(ix(2, 'h55), 16'h0098);
        check("R11 from read", mode_o, 3'd3);
        wr(ix(0, 0), 16'h00F0);
        check("R11 exit2", mode_o, 3'd0);

        // R5 chip erase, R7 writes ignored
        unlock(0); wr(ix(0, U0), 16'h0080); unlock(0); wr(ix(0, U0), 16'h0010);
        check("R5 start", erase_start_o, 1'b1);
        check("R5 kind", erase_chip_o, 1'b1);
        check("R5 mode", mode_o, 3'd4);
        for (int i = 0; i < DEPTH; i++) model[i] = '1;
        wr(ix(0, 0), 16'h00F0);
        check("R5 one pulse", erase_start_o, 1'b0);
        check("R7 ignore F0", mode_o, 3'd4);
        wr(ix(0, U0), 16'h00AA);
        check("R7 ignore", mode_o, 3'd4);
        finish_erase(3'd0, "R7 done");
        rd_chk("R5 filled", ix(3, 9), 16'hFFFF);
        rd_chk("R5 filled", ix(0, 14), 16'hFFFF);
        // R5 wrong final offset
        unlock(0); wr(ix(0, U0), 16'h0080); unlock(0); wr(ix(0, 3), 16'h0010);
        check("R5 abort", mode_o, 3'd0);
        check("R5 no start", erase_start_o, 1'b0);

        // R6 sector erase
        prog(ix(1, 5), 16'h1111); prog(ix(2, 5), 16'h2222); prog(ix(2, 127), 16'h2727);
        prog(ix(3, 0), 16'h3333);
        sect_erase(2, 'h33);
        rd_chk("R6 in", ix(2, 5), 16'hFFFF);
        rd_chk("R6 in end", ix(2, 127), 16'hFFFF);
        rd_chk("R6 below", ix(1, 5), 16'h1111);
        rd_chk("R6 above", ix(3, 0), 16'h3333);

        // R8 bypass
        unlock(0); wr(ix(0, U0), 16'h0020);
        check("R8 mode", mode_o, 3'd1);
        wr(ix(3, 7), 16'h00A0); wr(ix(3, 20), 16'h00FF); model[ix(3, 20)] = 16'h00FF;
        check("R8 back to cmd", mode_o, 3'd1);
        rd_chk("R8 prog", ix(3, 20), 16'h00FF);
        wr(ix(1, 1), 16'h00A0); wr(ix(3, 20), 16'h0F0F); model[ix(3, 20)] = 16'h000F;
        rd_chk("R8 prog2", ix(3, 20), 16'h000F);
        wr(ix(2, 2), 16'h0080); unlock(0); wr(ix(3, 1), 16'h0030);
        check("R8 erase", mode_o, 3'd4);
        finish_erase(3'd1, "R7 bypass return");
        rd_chk("R8 erased", ix(3, 20), 16'hFFFF);
        model[ix(3, 20)] = '1; model[ix(3, 0)] = '1;
        // R10 exit from ID mode
        wr(ix(1, 9), 16'h0090);
        check("R10 id", mode_o, 3'd2);
        wr(ix(1, 9), 16'h0000);
        check("R10 exit", mode_o, 3'd0);
        wr(ix(0, U0), 16'h00A0);
        check("R10 bypass off", mode_o, 3'd0);
        // R4 clears bypass
        unlock(0); wr(ix(0, U0), 16'h0020); wr(ix(0, 1), 16'h00F0);
        check("R4 clear bypass", mode_o, 3'd0);
        wr(ix(0, 1), 16'h00A0);
        check("R4 bypass gone", mode_o, 3'd0);

        // R12 read-only
        ro_i = 1'b1;
        prog(ix(1, 5), 16'h0000);
        check("R12 seq", mode_o, 3'd0);
        rd_chk("R12 prog blocked", ix(1, 5), 16'h1111);
        unlock(0); wr(ix(0, U0), 16'h0080); unlock(0); wr(ix(0, U0), 16'h0010);
        check("R12 pulse", erase_start_o, 1'b1);
        finish_erase(3'd0, "R12 done");
        rd_chk("R12 erase blocked", ix(1, 5), 16'h1111);
        ro_i = 1'b0;

        // random programs and sector erases against the shadow array (R3, R6)
        for (int k = 0; k < 60; k++) begin
            int idx;
            logic [W-1:0] d;
            idx = int'($urandom % DEPTH);
            d = W'($urandom);
            if ($urandom % 5 == 0) begin
                sect_erase(idx / SW, int'($urandom % SW));
            end else begin
                prog(idx, d);
            end
            rd_chk("R3 random", idx, model[idx]);
        end
        for (int i = 0; i < DEPTH; i += 8) rd_chk("R6 sweep", i, model[i]);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule